// File: doc/BRIEF.md
# Sideband Receive Endpoint with Completion Return

The endpoint takes one inbound sideband message at a time from a valid/ready port. It holds the message header, address, security tag and payload in registers that the processor can read, and it raises a received status and an interrupt. The processor works on the message and then pulses a completion trigger. That pulse clears the received status. If the original message was a non-posted request, the pulse also queues a completion on an outbound valid/ready port. The completion carries a status code and data that firmware supplies. Posted messages and completion-class messages are retired without any return traffic.

An access-enable level gates ordinary traffic. While it is low, ordinary messages are still drained from the port but are thrown away. A boot-preparation message is always accepted, whatever the access-enable level. It raises a status bit and an interrupt that cannot be masked. Firmware can clear that bit with a pulse. If firmware does not clear it within `BOOT_TIMEOUT` cycles, the hardware clears the bit itself and sends an acknowledge on the same outbound port.

Top module: `sbrx_endpoint`

## Requirements
- R1: After reset, `inReady` is 1, and `rxStatus`, `rxIrq`, `bootStatus`, `bootIrq` and `cplValid` are all 0. All captured fields are 0.
- R2: An ordinary message accepted while `accessEn` is 1 copies every field into the `cap*` outputs, starting the cycle after the handshake. The transaction class is `capKind`: 01 posted, 10 non-posted, 11 completion. `capAddrLong` 0 marks a 16-bit address and 1 marks a 48-bit address, where `capAddrHi` holds the upper bits.
- R3: `rxStatus` rises on the cycle after capture. `inReady` stays 0 while `rxStatus` is 1 or while a normal completion waits on the outbound port.
- R4: `rxIrq` equals `rxStatus` when `rxIrqMask` is 0, and is 0 when the mask is 1. The mask never changes `rxStatus`.
- R5: A `cplTrigger` pulse while `rxStatus` is 1 clears `rxStatus` on the next cycle. A pulse while `rxStatus` is 0 changes nothing.
- R6: A trigger for a non-posted (10) original offers a completion on the next cycle: `cplIsAck` 0, `cplOutStatus` and `cplOutData` taken from `cplStatus`/`cplData` at the trigger, and `cplOutDst` equal to the captured source port. Status 000 means success and 001 means unsupported request. The offer stays valid and unchanged until `cplReady` is 1.
- R7: A trigger for a posted (01) or completion-class (11) original produces no completion.
- R8: With `accessEn` 0, an ordinary message is still accepted (`inReady` 1). It leaves `rxStatus` at 0 and the captured fields unchanged.
- R9: A boot-prep message (`inBootPrep` 1) sets `bootStatus` and `bootIrq` on the next cycle, whatever `accessEn` is. It leaves `rxStatus` and the captured fields unchanged.
- R10: A `bootClr` pulse clears `bootStatus` on the next cycle, and no acknowledge follows.
- R11: If `bootStatus` is not cleared, it stays 1 for exactly `BOOT_TIMEOUT` cycles and then falls. On that same edge an acknowledge is offered with `cplIsAck` 1, status 000, data 0, and `cplOutDst` equal to the boot-prep source port.
- R12: If a normal completion and an acknowledge become pending on the same edge, the normal completion is offered first and the acknowledge follows after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Inbound message valid |
| inReady | output | 1 | Inbound message ready |
| inBootPrep | input | 1 | Inbound message is a boot-prep message |
| inKind | input | 2 | Transaction class: 01 posted, 10 non-posted, 11 completion |
| inDstPort | input | PORT_W | Destination port id |
| inSrcPort | input | PORT_W | Source port id |
| inOpcode | input | 8 | Opcode |
| inByteEn | input | BE_W | Byte enables |
| inAddrLong | input | 1 | 1 = 48-bit address, 0 = 16-bit address |
| inAddrLo | input | ADDR_LO_W | Lower address bits |
| inAddrHi | input | ADDR_HI_W | Upper address bits |
| inSecId | input | SAI_W | Security attribute tag |
| inRootSpace | input | RS_W | Root space |
| inExtHdr | input | 1 | Extended header present |
| inData | input | DATA_W | Payload |
| accessEn | input | 1 | Accept ordinary messages when 1 |
| rxIrqMask | input | 1 | Masks the receive interrupt |
| cplTrigger | input | 1 | Firmware pulse: message consumed |
| cplStatus | input | 3 | Completion status to return |
| cplData | input | DATA_W | Completion data to return |
| bootClr | input | 1 | Firmware pulse clearing the boot-prep status |
| rxStatus | output | 1 | Message held |
| rxIrq | output | 1 | Receive interrupt |
| bootStatus | output | 1 | Boot-prep message pending |
| bootIrq | output | 1 | Boot-prep interrupt |
| capKind | output | 2 | Captured transaction class |
| capDstPort | output | PORT_W | Captured destination port |
| capSrcPort | output | PORT_W | Captured source port |
| capOpcode | output | 8 | Captured opcode |
| capByteEn | output | BE_W | Captured byte enables |
| capAddrLong | output | 1 | Captured address-length flag |
| capAddrLo | output | ADDR_LO_W | Captured lower address |
| capAddrHi | output | ADDR_HI_W | Captured upper address |
| capSecId | output | SAI_W | Captured security tag |
| capRootSpace | output | RS_W | Captured root space |
| capExtHdr | output | 1 | Captured extended-header flag |
| capData | output | DATA_W | Captured payload |
| cplValid | output | 1 | Outbound completion/acknowledge valid |
| cplReady | input | 1 | Outbound ready |
| cplIsAck | output | 1 | 1 = boot-prep acknowledge, 0 = normal completion |
| cplOutStatus | output | 3 | Outbound status |
| cplOutData | output | DATA_W | Outbound data |
| cplOutDst | output | PORT_W | Outbound destination port |

## Verification
The normal completion of a non-posted message and the boot-prep timeout acknowledge can both become pending on the same clock edge, and they compete for the single outbound port. The bench provokes this by accepting a boot-prep message and then a non-posted message one cycle later. It then times the completion trigger so that it lands on exactly the edge where the boot timer expires, while `cplReady` is held low. The check is that the normal completion is offered first with its own status, data and destination. The acknowledge must come next, with its destination and zero status. `bootStatus` must have fallen on that same edge, and the port must go idle after both are taken.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;

  localparam int STS_W = 3;
  localparam int OPC_W = 8;

  typedef enum logic [1:0] {
    KIND_NONE      = 2'b00,
    KIND_POSTED    = 2'b01,
    KIND_NONPOSTED = 2'b10,
    KIND_CPL       = 2'b11
  } msgKind_e;

  localparam logic [STS_W-1:0] STS_SUCCESS = 3'b000;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch ordinary message fields
    logic bootLoad;  // latch boot-prep source port
    logic cplLoad;   // latch firmware completion status/data
    logic ackLoad;   // latch acknowledge destination
    logic selAck;    // outbound port presents the acknowledge
  } dpStrobes_t;

endpackage

// File: rtl/sbrx_datapath.sv
module sbrx_datapath
  import sbrx_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int BE_W      = 4,
  parameter int ADDR_LO_W = 32,
  parameter int ADDR_HI_W = 16,
  parameter int SAI_W     = 16,
  parameter int RS_W      = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobes_t           strb,
  input  logic [1:0]           inKind,
  input  logic [PORT_W-1:0]    inDstPort,
  input  logic [PORT_W-1:0]    inSrcPort,
  input  logic [OPC_W-1:0]     inOpcode,
  input  logic [BE_W-1:0]      inByteEn,
  input  logic                 inAddrLong,
  input  logic [ADDR_LO_W-1:0] inAddrLo,
  input  logic [ADDR_HI_W-1:0] inAddrHi,
  input  logic [SAI_W-1:0]     inSecId,
  input  logic [RS_W-1:0]      inRootSpace,
  input  logic                 inExtHdr,
  input  logic [DATA_W-1:0]    inData,
  input  logic [STS_W-1:0]     cplStatus,
  input  logic [DATA_W-1:0]    cplData,
  output logic [1:0]           capKind,
  output logic [PORT_W-1:0]    capDstPort,
  output logic [PORT_W-1:0]    capSrcPort,
  output logic [OPC_W-1:0]     capOpcode,
  output logic [BE_W-1:0]      capByteEn,
  output logic                 capAddrLong,
  output logic [ADDR_LO_W-1:0] capAddrLo,
  output logic [ADDR_HI_W-1:0] capAddrHi,
  output logic [SAI_W-1:0]     capSecId,
  output logic [RS_W-1:0]      capRootSpace,
  output logic                 capExtHdr,
  output logic [DATA_W-1:0]    capData,
  output logic [STS_W-1:0]     cplOutStatus,
  output logic [DATA_W-1:0]    cplOutData,
  output logic [PORT_W-1:0]    cplOutDst
);

  logic [PORT_W-1:0] bootSrc;
  logic [PORT_W-1:0] ackDst;
  logic [STS_W-1:0]  cplStsQ;
  logic [DATA_W-1:0] cplDataQ;

  // captured message image
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capKind      <= '0;
      capDstPort   <= '0;
      capSrcPort   <= '0;
      capOpcode    <= '0;
      capByteEn    <= '0;
      capAddrLong  <= 1'b0;
      capAddrLo    <= '0;
      capAddrHi    <= '0;
      capSecId     <= '0;
      capRootSpace <= '0;
      capExtHdr    <= 1'b0;
      capData      <= '0;
    end else if (strb.capture) begin
      capKind      <= inKind;
      capDstPort   <= inDstPort;
      capSrcPort   <= inSrcPort;
      capOpcode    <= inOpcode;
      capByteEn    <= inByteEn;
      capAddrLong  <= inAddrLong;
      capAddrLo    <= inAddrLo;
      capAddrHi    <= inAddrHi;
      capSecId     <= inSecId;
      capRootSpace <= inRootSpace;
      capExtHdr    <= inExtHdr;
      capData      <= inData;
    end
  end

  // firmware completion payload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cplStsQ  <= '0;
      cplDataQ <= '0;
    end else if (strb.cplLoad) begin
      cplStsQ  <= cplStatus;
      cplDataQ <= cplData;
    end
  end

  // boot-prep requester and acknowledge destination
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootSrc <= '0;
      ackDst  <= '0;
    end else begin
      if (strb.bootLoad) bootSrc <= inSrcPort;
      if (strb.ackLoad)  ackDst  <= bootSrc;
    end
  end

  always_comb begin
    if (strb.selAck) begin
      cplOutStatus = STS_SUCCESS;
      cplOutData   = '0;
      cplOutDst    = ackDst;
    end else begin
      cplOutStatus = cplStsQ;
      cplOutData   = cplDataQ;
      cplOutDst    = capSrcPort;
    end
  end

  // R2: captured image only moves on a capture strobe
  assert_cap_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(capData) && $stable(capKind) && $stable(capSrcPort)));

endmodule

// File: rtl/sbrx_ctrl.sv
module sbrx_ctrl
  import sbrx_pkg::*;
#(
  parameter int BOOT_TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inBootPrep,
  input  logic       accessEn,
  input  logic       rxIrqMask,
  input  logic       cplTrigger,
  input  logic       bootClr,
  input  logic       cplReady,
  input  logic [1:0] capKind,
  output logic       inReady,
  output logic       rxStatus,
  output logic       rxIrq,
  output logic       bootStatus,
  output logic       bootIrq,
  output logic       cplValid,
  output logic       cplIsAck,
  output dpStrobes_t strb
);

  localparam int CNT_W = $clog2(BOOT_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BOOT_TIMEOUT - 1);

  logic             rxSt;
  logic             cplPend;
  logic             ackPend;
  logic             ackLead;
  logic             bootSt;
  logic [CNT_W-1:0] bootCnt;

  logic accept, ordHit, bootHit, trigHit, npLoad, timeout, outFire, selAck;

  assign inReady = !rxSt && !cplPend;
  assign accept  = inValid && inReady;
  assign ordHit  = accept && !inBootPrep && accessEn;
  assign bootHit = accept && inBootPrep;
  assign trigHit = cplTrigger && rxSt;
  assign npLoad  = trigHit && (capKind == KIND_NONPOSTED);
  assign timeout = bootSt && !bootHit && (bootCnt == CNT_LAST);
  assign selAck  = ackPend && (!cplPend || ackLead);
  assign outFire = (cplPend || ackPend) && cplReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt    <= 1'b0;
      cplPend <= 1'b0;
      ackPend <= 1'b0;
      ackLead <= 1'b0;
    end else begin
      if (ordHit)       rxSt <= 1'b1;
      else if (trigHit) rxSt <= 1'b0;

      if (npLoad)                   cplPend <= 1'b1;
      else if (outFire && !selAck)  cplPend <= 1'b0;

      if (timeout)                  ackPend <= 1'b1;
      else if (outFire && selAck)   ackPend <= 1'b0;

      ackLead <= selAck && !outFire;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootSt  <= 1'b0;
      bootCnt <= '0;
    end else begin
      if (bootHit)                  bootSt <= 1'b1;
      else if (bootClr || timeout)  bootSt <= 1'b0;

      if (bootHit)     bootCnt <= '0;
      else if (bootSt) bootCnt <= bootCnt + 1'b1;
      else             bootCnt <= '0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.capture  = ordHit;
    strb.bootLoad = bootHit;
    strb.cplLoad  = npLoad;
    strb.ackLoad  = timeout && !ackPend;
    strb.selAck   = selAck;
  end

  assign rxStatus   = rxSt;
  assign rxIrq      = rxSt && !rxIrqMask;
  assign bootStatus = bootSt;
  assign bootIrq    = bootSt;
  assign cplValid   = cplPend || ackPend;
  assign cplIsAck   = selAck;

  // R3: nothing is taken while a message is held
  assert_hold_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxStatus |-> !inReady);

  // R4: masked interrupt stays low
  assert_irq_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxIrqMask |-> !rxIrq);

  // R7: posted or completion-class originals produce no return traffic
  assert_posted_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cplTrigger && rxStatus && capKind != KIND_NONPOSTED) |=> !cplPend);

  // R8: discarded traffic raises no status
  assert_discard_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !inBootPrep && !accessEn && !rxStatus) |=> !rxStatus);

  // R9: boot-prep bypasses the access gate
  assert_boot_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inBootPrep) |=> bootIrq);

  // R10, R11: boot status falls only by firmware clear or with an acknowledge queued
  assert_boot_fall_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bootStatus) |-> ($past(bootClr) || ackPend));

endmodule

// File: rtl/sbrx_endpoint.sv
module sbrx_endpoint
  import sbrx_pkg::*;
#(
  parameter int PORT_W       = 8,
  parameter int BE_W         = 4,
  parameter int ADDR_LO_W    = 32,
  parameter int ADDR_HI_W    = 16,
  parameter int SAI_W        = 16,
  parameter int RS_W         = 4,
  parameter int DATA_W       = 32,
  parameter int BOOT_TIMEOUT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic                 inBootPrep,
  input  logic [1:0]           inKind,
  input  logic [PORT_W-1:0]    inDstPort,
  input  logic [PORT_W-1:0]    inSrcPort,
  input  logic [7:0]           inOpcode,
  input  logic [BE_W-1:0]      inByteEn,
  input  logic                 inAddrLong,
  input  logic [ADDR_LO_W-1:0] inAddrLo,
  input  logic [ADDR_HI_W-1:0] inAddrHi,
  input  logic [SAI_W-1:0]     inSecId,
  input  logic [RS_W-1:0]      inRootSpace,
  input  logic                 inExtHdr,
  input  logic [DATA_W-1:0]    inData,
  input  logic                 accessEn,
  input  logic                 rxIrqMask,
  input  logic                 cplTrigger,
  input  logic [2:0]           cplStatus,
  input  logic [DATA_W-1:0]    cplData,
  input  logic                 bootClr,
  output logic                 rxStatus,
  output logic                 rxIrq,
  output logic                 bootStatus,
  output logic                 bootIrq,
  output logic [1:0]           capKind,
  output logic [PORT_W-1:0]    capDstPort,
  output logic [PORT_W-1:0]    capSrcPort,
  output logic [7:0]           capOpcode,
  output logic [BE_W-1:0]      capByteEn,
  output logic                 capAddrLong,
  output logic [ADDR_LO_W-1:0] capAddrLo,
  output logic [ADDR_HI_W-1:0] capAddrHi,
  output logic [SAI_W-1:0]     capSecId,
  output logic [RS_W-1:0]      capRootSpace,
  output logic                 capExtHdr,
  output logic [DATA_W-1:0]    capData,
  output logic                 cplValid,
  input  logic                 cplReady,
  output logic                 cplIsAck,
  output logic [2:0]           cplOutStatus,
  output logic [DATA_W-1:0]    cplOutData,
  output logic [PORT_W-1:0]    cplOutDst
);

  dpStrobes_t strb;

  sbrx_ctrl #(.BOOT_TIMEOUT(BOOT_TIMEOUT)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inBootPrep (inBootPrep),
    .accessEn   (accessEn),
    .rxIrqMask  (rxIrqMask),
    .cplTrigger (cplTrigger),
    .bootClr    (bootClr),
    .cplReady   (cplReady),
    .capKind    (capKind),
    .inReady    (inReady),
    .rxStatus   (rxStatus),
    .rxIrq      (rxIrq),
    .bootStatus (bootStatus),
    .bootIrq    (bootIrq),
    .cplValid   (cplValid),
    .cplIsAck   (cplIsAck),
    .strb       (strb)
  );

  sbrx_datapath #(
    .PORT_W(PORT_W), .BE_W(BE_W), .ADDR_LO_W(ADDR_LO_W), .ADDR_HI_W(ADDR_HI_W),
    .SAI_W(SAI_W), .RS_W(RS_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .inKind       (inKind),
    .inDstPort    (inDstPort),
    .inSrcPort    (inSrcPort),
    .inOpcode     (inOpcode),
    .inByteEn     (inByteEn),
    .inAddrLong   (inAddrLong),
    .inAddrLo     (inAddrLo),
    .inAddrHi     (inAddrHi),
    .inSecId      (inSecId),
    .inRootSpace  (inRootSpace),
    .inExtHdr     (inExtHdr),
    .inData       (inData),
    .cplStatus    (cplStatus),
    .cplData      (cplData),
    .capKind      (capKind),
    .capDstPort   (capDstPort),
    .capSrcPort   (capSrcPort),
    .capOpcode    (capOpcode),
    .capByteEn    (capByteEn),
    .capAddrLong  (capAddrLong),
    .capAddrLo    (capAddrLo),
    .capAddrHi    (capAddrHi),
    .capSecId     (capSecId),
    .capRootSpace (capRootSpace),
    .capExtHdr    (capExtHdr),
    .capData      (capData),
    .cplOutStatus (cplOutStatus),
    .cplOutData   (cplOutData),
    .cplOutDst    (cplOutDst)
  );

  // R6: an offered completion holds until taken
  assert_cpl_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && !cplReady) |=> (cplValid && $stable(cplIsAck) &&
                                 $stable(cplOutData) && $stable(cplOutDst) &&
                                 $stable(cplOutStatus)));

  // R5: a trigger with nothing held leaves the port idle
  assert_idle_trigger_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cplTrigger && !rxStatus && !cplValid && !bootStatus) |=> !cplValid);

endmodule

// File: tb/sbrx_endpoint_tb_top.sv
module sbrx_endpoint_tb_top;

  typedef struct packed {
    logic        acc;
    logic [1:0]  kind;
    logic [7:0]  dst;
    logic [7:0]  src;
    logic [7:0]  opc;
    logic [3:0]  be;
    logic        aLong;
    logic [31:0] aLo;
    logic [15:0] aHi;
    logic [15:0] sai;
    logic [3:0]  rs;
    logic        ehp;
    logic [31:0] data;
    logic [2:0]  fwSts;
    logic [31:0] fwData;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b10, 8'h11, 8'h21, 8'h01, 4'hF, 1'b0, 32'h0000_1234, 16'h0000, 16'hA5A5, 4'h1, 1'b1, 32'hDEAD_BEEF, 3'b000, 32'h1111_2222},
    '{1'b1, 2'b01, 8'h12, 8'h22, 8'h02, 4'h3, 1'b1, 32'h8765_4321, 16'hCAFE, 16'h0F0F, 4'h2, 1'b0, 32'h0BAD_F00D, 3'b000, 32'h3333_4444},
    '{1'b0, 2'b10, 8'h13, 8'h23, 8'h03, 4'h1, 1'b0, 32'h0000_5555, 16'h0000, 16'h1234, 4'h3, 1'b1, 32'h5555_5555, 3'b001, 32'h5555_6666},
    '{1'b1, 2'b11, 8'h14, 8'h24, 8'h04, 4'h8, 1'b0, 32'h0000_0040, 16'h0000, 16'hFFFF, 4'hF, 1'b1, 32'h1357_9BDF, 3'b000, 32'h7777_8888},
    '{1'b1, 2'b10, 8'h15, 8'h25, 8'h05, 4'hC, 1'b1, 32'hFFFF_0000, 16'h1FFF, 16'h8001, 4'h7, 1'b1, 32'h2468_ACE0, 3'b001, 32'h9999_AAAA},
    '{1'b0, 2'b01, 8'h16, 8'h26, 8'h06, 4'h2, 1'b1, 32'h0101_0101, 16'h0202, 16'h0303, 4'h4, 1'b0, 32'h0404_0404, 3'b000, 32'hBBBB_CCCC}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inBootPrep = 1'b0;
  logic [1:0]  inKind = '0;
  logic [7:0]  inDstPort = '0, inSrcPort = '0, inOpcode = '0;
  logic [3:0]  inByteEn = '0, inRootSpace = '0;
  logic        inAddrLong = 1'b0, inExtHdr = 1'b0;
  logic [31:0] inAddrLo = '0, inData = '0, cplData = '0;
  logic [15:0] inAddrHi = '0, inSecId = '0;
  logic        accessEn = 1'b0, rxIrqMask = 1'b0, cplTrigger = 1'b0, bootClr = 1'b0;
  logic [2:0]  cplStatus = '0;
  logic        cplReady = 1'b0;
  logic        inReady, rxStatus, rxIrq, bootStatus, bootIrq;
  logic [1:0]  capKind;
  logic [7:0]  capDstPort, capSrcPort, capOpcode, cplOutDst;
  logic [3:0]  capByteEn, capRootSpace;
  logic        capAddrLong, capExtHdr, cplValid, cplIsAck;
  logic [31:0] capAddrLo, capData, cplOutData;
  logic [15:0] capAddrHi, capSecId;
  logic [2:0]  cplOutStatus;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sbrx_endpoint #(.BOOT_TIMEOUT(16)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inBootPrep(inBootPrep), .inKind(inKind), .inDstPort(inDstPort),
    .inSrcPort(inSrcPort), .inOpcode(inOpcode), .inByteEn(inByteEn),
    .inAddrLong(inAddrLong), .inAddrLo(inAddrLo), .inAddrHi(inAddrHi),
    .inSecId(inSecId), .inRootSpace(inRootSpace), .inExtHdr(inExtHdr),
    .inData(inData), .accessEn(accessEn), .rxIrqMask(rxIrqMask),
    .cplTrigger(cplTrigger), .cplStatus(cplStatus), .cplData(cplData),
    .bootClr(bootClr), .rxStatus(rxStatus), .rxIrq(rxIrq),
    .bootStatus(bootStatus), .bootIrq(bootIrq), .capKind(capKind),
    .capDstPort(capDstPort), .capSrcPort(capSrcPort), .capOpcode(capOpcode),
    .capByteEn(capByteEn), .capAddrLong(capAddrLong), .capAddrLo(capAddrLo),
    .capAddrHi(capAddrHi), .capSecId(capSecId), .capRootSpace(capRootSpace),
    .capExtHdr(capExtHdr), .capData(capData), .cplValid(cplValid),
    .cplReady(cplReady), .cplIsAck(cplIsAck), .cplOutStatus(cplOutStatus),
    .cplOutData(cplOutData), .cplOutDst(cplOutDst)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic sendMsg(input vec_t v, input logic boot);
    inValid = 1'b1; inBootPrep = boot; inKind = v.kind;
    inDstPort = v.dst; inSrcPort = v.src; inOpcode = v.opc; inByteEn = v.be;
    inAddrLong = v.aLong; inAddrLo = v.aLo; inAddrHi = v.aHi;
    inSecId = v.sai; inRootSpace = v.rs; inExtHdr = v.ehp; inData = v.data;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; inBootPrep = 1'b0;
  endtask

  task automatic trigger(input logic [2:0] sts, input logic [31:0] d);
    cplStatus = sts; cplData = d; cplTrigger = 1'b1;
    @(negedge clk);
    cplTrigger = 1'b0;
  endtask

  task automatic takeOne();
    cplReady = 1'b1;
    @(negedge clk);
    cplReady = 1'b0;
  endtask

  task automatic checkFields(input string req, input vec_t v);
    check(req, {62'd0, capKind}, {62'd0, v.kind});
    check(req, {capDstPort, capSrcPort, capOpcode, capByteEn}, {v.dst, v.src, v.opc, v.be});
    check(req, {capAddrLong, capAddrLo, capAddrHi}, {v.aLong, v.aLo, v.aHi});
    check(req, {capSecId, capRootSpace, capExtHdr}, {v.sai, v.rs, v.ehp});
    check(req, {32'd0, capData}, {32'd0, v.data});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    vec_t lastCap;
    vec_t bootV;
    lastCap = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", {63'd0, inReady}, 64'd1);
    check("R1 status", {60'd0, rxStatus, rxIrq, bootStatus, bootIrq}, 64'd0);
    check("R1 cplValid", {63'd0, cplValid}, 64'd0);
    check("R1 capData", {32'd0, capData}, 64'd0);

    // R5 trigger with nothing held is ignored
    trigger(3'b001, 32'hFFFF_FFFF);
    check("R5 idle trigger status", {63'd0, rxStatus}, 64'd0);
    check("R5 idle trigger cpl", {63'd0, cplValid}, 64'd0);

    // table walk: R2, R3, R6, R7, R8
    for (int i = 0; i < NV; i++) begin
      accessEn = VEC[i].acc;
      check("R8 ready before send", {63'd0, inReady}, 64'd1);
      sendMsg(VEC[i], 1'b0);
      if (VEC[i].acc) begin
        lastCap = VEC[i];
        check("R3 status set", {63'd0, rxStatus}, 64'd1);
        check("R3 ready low", {63'd0, inReady}, 64'd0);
        checkFields("R2 capture", lastCap);
        trigger(VEC[i].fwSts, VEC[i].fwData);
        check("R5 status cleared", {63'd0, rxStatus}, 64'd0);
        if (VEC[i].kind == 2'b10) begin
          check("R6 cpl valid", {63'd0, cplValid}, 64'd1);
          check("R6 cpl fields", {cplIsAck, cplOutStatus, cplOutDst, cplOutData},
                {1'b0, VEC[i].fwSts, VEC[i].src, VEC[i].fwData});
          check("R3 ready low while cpl pending", {63'd0, inReady}, 64'd0);
          takeOne();
        end
        check("R7 port idle", {63'd0, cplValid}, 64'd0);
      end else begin
        check("R8 no status", {63'd0, rxStatus}, 64'd0);
        checkFields("R8 fields unchanged", lastCap);
      end
    end

    // R4 masking
    accessEn = 1'b1;
    rxIrqMask = 1'b1;
    sendMsg(VEC[1], 1'b0);
    check("R4 masked status", {62'd0, rxStatus, rxIrq}, 64'b10);
    rxIrqMask = 1'b0;
    @(negedge clk);
    check("R4 unmasked", {62'd0, rxStatus, rxIrq}, 64'b11);
    trigger(3'b000, 32'h0);
    check("R7 posted no cpl", {63'd0, cplValid}, 64'd0);
    lastCap = VEC[1];

    // R6 back-pressure hold
    sendMsg(VEC[0], 1'b0);
    lastCap = VEC[0];
    trigger(3'b001, 32'hABCD_0123);
    repeat (3) @(negedge clk);
    check("R6 held", {cplValid, cplIsAck, cplOutStatus, cplOutDst, cplOutData},
          {1'b1, 1'b0, 3'b001, VEC[0].src, 32'hABCD_0123});
    takeOne();
    check("R6 taken", {63'd0, cplValid}, 64'd0);

    // R9, R10 boot-prep with access disabled then firmware clear
    accessEn = 1'b0;
    bootV = VEC[2];
    bootV.src = 8'h5A;
    bootV.data = 32'hFACE_FACE;
    sendMsg(bootV, 1'b1);
    check("R9 boot status", {62'd0, bootStatus, bootIrq}, 64'b11);
    check("R9 rx untouched", {63'd0, rxStatus}, 64'd0);
    checkFields("R9 fields unchanged", lastCap);
    bootClr = 1'b1;
    @(negedge clk);
    bootClr = 1'b0;
    check("R10 cleared", {63'd0, bootStatus}, 64'd0);
    repeat (20) @(negedge clk);
    check("R10 no ack", {63'd0, cplValid}, 64'd0);

    // R11 timeout auto-acknowledge
    sendMsg(bootV, 1'b1);
    check("R11 set", {63'd0, bootStatus}, 64'd1);
    repeat (15) @(negedge clk);
    check("R11 still set at last cycle", {63'd0, bootStatus}, 64'd1);
    check("R11 no early ack", {63'd0, cplValid}, 64'd0);
    @(negedge clk);
    check("R11 cleared on expiry", {63'd0, bootStatus}, 64'd0);
    check("R11 ack", {cplValid, cplIsAck, cplOutStatus, cplOutDst, cplOutData},
          {1'b1, 1'b1, 3'b000, 8'h5A, 32'h0});
    takeOne();
    check("R11 ack taken", {63'd0, cplValid}, 64'd0);

    // R12 completion and acknowledge pending on the same edge
    accessEn = 1'b1;
    bootV.src = 8'h6B;
    sendMsg(bootV, 1'b1);          // accept edge k
    sendMsg(VEC[4], 1'b0);         // accept edge k+1
    repeat (14) @(negedge clk);    // after edge k+15
    trigger(3'b010, 32'h0F0F_F0F0); // lands on edge k+16
    check("R12 boot fell", {63'd0, bootStatus}, 64'd0);
    check("R12 cpl first", {cplValid, cplIsAck, cplOutStatus, cplOutDst, cplOutData},
          {1'b1, 1'b0, 3'b010, VEC[4].src, 32'h0F0F_F0F0});
    @(negedge clk);
    check("R12 cpl held", {62'd0, cplValid, cplIsAck}, 64'b10);
    takeOne();
    check("R12 ack second", {cplValid, cplIsAck, cplOutStatus, cplOutDst},
          {1'b1, 1'b1, 3'b000, 8'h6B});
    takeOne();
    check("R12 idle", {63'd0, cplValid}, 64'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule